// File: doc/BRIEF.md
# NAND EDC Unit Write-Rule Monitor

This block sits beside a NAND host controller and watches its decoded command and data-input events. While a program sequence or a copy-back sequence is open, it records every column the host loads into the page buffer. It raises sticky flags when the traffic breaks the on-die error-detection rules for a unit. One rule is that an error-detection unit (a group of `UNIT_BYTES` columns) may take only one partial program per page. Another is that each column may be loaded at most once per sequence. During copy-back with checking enabled, it also judges whether every touched unit was fully rewritten. That judgement decides whether the die's error-detection result can be trusted.

When the host issues the read-EDC-status opcode after a copy-back program has been confirmed, the block returns a formatted status byte. The byte combines the pass/fail input, a sticky error-detection error bit, the computed validity bit, two ready levels and the write-protect level. An error bit merges all read-error pulses, so the planes of a multiplane copy-back cannot be told apart. A status read with no completed copy-back behind it returns zero and sets a protocol-error flag.

Top module: `edc_rule_monitor`

## Requirements
- R1: A program confirm (opcode 10h or 15h) that includes an error-detection unit already programmed by an earlier confirm sets `viol_partial`. The history of programmed units is cleared by reset or by `new_page`. A unit index is column / `UNIT_BYTES`.
- R2: In a program sequence (opened by opcode 80h), a second `wr_stb` to a column already loaded in that sequence sets `viol_col` after one clock. Distinct columns never set it.
- R3: At the confirm of a copy-back started with `cb_chk_en`=1, `edc_valid` becomes 1 only if every unit touched in that sequence got all `UNIT_BYTES` of its columns. Otherwise it becomes 0.
- R4: In a copy-back sequence with checking enabled, a repeated column sets `viol_col`.
- R5: In a copy-back started with `cb_chk_en`=0, no column traffic raises a violation, and `edc_valid` reads 0 after the confirm.
- R6: Opcode 7Bh after a confirmed copy-back returns the status byte one clock later, with `stat_vld` high for that clock. Its layout is: bit0 `prog_fail`, bit1 error-detection error, bit2 `edc_valid`, bit5 `arr_rdy`, bit6 `rdy`, bit7 `wp_n`, and bits 4:3 zero.
- R7: Opcode 7Bh with no confirmed copy-back since the last sequence start returns 00h and sets `proto_err`.
- R8: The error-detection error bit is set by any `cb_rd_err` pulse, and several pulses merge into one bit. It is cleared by opcode 80h or by a status read that reports it.
- R9: `viol_partial`, `viol_col` and `proto_err` stay set until the next sequence start (opcode 80h or `cb_start`), which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command opcode strobe |
| cmd_op | input | 8 | Command opcode (80h setup, 10h/15h confirm, 7Bh status) |
| wr_stb | input | 1 | One data byte loaded at `wr_col` |
| wr_col | input | 12 | Column address of the loaded byte |
| new_page | input | 1 | Host moved to another page; clears programmed-unit history |
| cb_start | input | 1 | Copy-back program sequence opens |
| cb_chk_en | input | 1 | Copy-back uses error-detection checking (sampled at `cb_start`) |
| cb_rd_err | input | 1 | Copy-back read reported an error-detection error |
| prog_fail | input | 1 | Program result, 1 = fail |
| arr_rdy | input | 1 | Array ready level |
| rdy | input | 1 | Device ready level |
| wp_n | input | 1 | Write-protect level, 1 = not protected |
| viol_partial | output | 1 | Sticky: second partial program into a unit |
| viol_col | output | 1 | Sticky: a column was loaded twice |
| edc_valid | output | 1 | Copy-back check result can be trusted |
| proto_err | output | 1 | Sticky: status read outside copy-back context |
| stat_vld | output | 1 | Status byte updated this cycle |
| stat_byte | output | 8 | Formatted error-detection status |

## Verification
The hardest state to reach is a valid copy-back result. It needs an entire unit of 528 distinct columns loaded in one sequence, with no repeated column, before the confirm. The bench gets there with a loop that walks a unit's column range byte by byte. It pairs this with a run that stops one column short, so both sides of the fullness boundary are observed through the status byte. Read-error pulses are placed inside such a full sequence, which separates the error bit from the validity bit in the same byte.

// File: rtl/edc_mon_pkg.sv
package edc_mon_pkg;

  localparam logic [7:0] OP_PROG_SETUP = 8'h80;
  localparam logic [7:0] OP_CONFIRM    = 8'h10;
  localparam logic [7:0] OP_CACHE_CONF = 8'h15;
  localparam logic [7:0] OP_EDC_STATUS = 8'h7B;

  localparam int BIT_FAIL  = 0;
  localparam int BIT_ERR   = 1;
  localparam int BIT_VALID = 2;
  localparam int BIT_ARDY  = 5;
  localparam int BIT_RDY   = 6;
  localparam int BIT_WPN   = 7;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_PROG, SEQ_CB} seq_mode_e;

  function automatic int unsigned unit_of(input int unsigned col, input int unsigned ub);
    return col / ub;
  endfunction

  function automatic logic [7:0] pack_status(input logic fail, input logic err,
                                             input logic valid, input logic ardy,
                                             input logic rdy, input logic wpn);
    logic [7:0] s;
    s = 8'h00;
    s[BIT_FAIL]  = fail;
    s[BIT_ERR]   = err;
    s[BIT_VALID] = valid;
    s[BIT_ARDY]  = ardy;
    s[BIT_RDY]   = rdy;
    s[BIT_WPN]   = wpn;
    return s;
  endfunction

endpackage

// File: rtl/edc_col_tracker.sv
module edc_col_tracker
  import edc_mon_pkg::*;
#(
  parameter int UNIT_BYTES = 528,
  parameter int UNITS      = 4,
  localparam int PAGE_COLS = UNIT_BYTES * UNITS,
  localparam int COL_W     = $clog2(PAGE_COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             trk_en,
  input  logic             wr_stb,
  input  logic [COL_W-1:0] wr_col,
  output logic             dup_evt,
  output logic [UNITS-1:0] touched,
  output logic [UNITS-1:0] unit_full
);
  localparam int CNT_W = $clog2(UNIT_BYTES + 1);

  logic [PAGE_COLS-1:0] seen;
  logic                 in_range;
  logic                 acc;
  logic                 fresh;
  int unsigned          wr_unit;

  assign in_range = 32'(wr_col) < PAGE_COLS;
  assign acc      = wr_stb && trk_en && in_range && !clr;
  assign wr_unit  = unit_of(32'(wr_col), UNIT_BYTES);
  assign dup_evt  = acc && seen[wr_col];
  assign fresh    = acc && !seen[wr_col];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) seen <= '0;
    else if (fresh)    seen[wr_col] <= 1'b1;
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic [CNT_W-1:0] cnt;
    logic             t_q;
    logic             hit;
    assign hit = acc && (wr_unit == 32'(u));

    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        cnt <= '0;
        t_q <= 1'b0;
      end else if (hit) begin
        t_q <= 1'b1;
        if (fresh) cnt <= cnt + 1'b1;
      end
    end

    assign touched[u]   = t_q;
    assign unit_full[u] = (cnt == CNT_W'(UNIT_BYTES));

    // R3: a unit count never passes the unit size
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) <= UNIT_BYTES);
  end

endmodule

// File: rtl/edc_seq_ctrl.sv
module edc_seq_ctrl
  import edc_mon_pkg::*;
#(
  parameter int UNITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic [7:0]       cmd_op,
  input  logic             cb_start,
  input  logic             cb_chk_en,
  input  logic             new_page,
  input  logic             dup_evt,
  input  logic [UNITS-1:0] touched,
  input  logic [UNITS-1:0] unit_full,
  output logic             seq_start,
  output logic             prog_start,
  output logic             trk_en,
  output logic             viol_partial,
  output logic             viol_col,
  output logic             edc_valid,
  output logic             cb_ctx
);
  seq_mode_e        mode;
  logic             chk_q;
  logic [UNITS-1:0] unit_done;
  logic             confirm;
  logic             prog_conf;
  logic             cb_conf;
  logic             partial_evt;
  logic             cb_valid_calc;

  assign prog_start    = cmd_vld && (cmd_op == OP_PROG_SETUP) && !cb_start;
  assign seq_start     = prog_start || cb_start;
  assign confirm       = cmd_vld && ((cmd_op == OP_CONFIRM) || (cmd_op == OP_CACHE_CONF))
                         && (mode != SEQ_IDLE) && !seq_start;
  assign prog_conf     = confirm && (mode == SEQ_PROG);
  assign cb_conf       = confirm && (mode == SEQ_CB);
  assign partial_evt   = prog_conf && |(touched & unit_done);
  assign cb_valid_calc = chk_q && &(unit_full | ~touched);
  assign trk_en        = (mode == SEQ_PROG) || ((mode == SEQ_CB) && chk_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= SEQ_IDLE;
      chk_q <= 1'b0;
    end else if (cb_start) begin
      mode  <= SEQ_CB;
      chk_q <= cb_chk_en;
    end else if (prog_start) begin
      mode  <= SEQ_PROG;
    end else if (confirm) begin
      mode  <= SEQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || new_page) unit_done <= '0;
    else if (prog_conf)     unit_done <= unit_done | touched;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || seq_start) begin
      viol_partial <= 1'b0;
      viol_col     <= 1'b0;
      edc_valid    <= 1'b0;
      cb_ctx       <= 1'b0;
    end else begin
      if (partial_evt) viol_partial <= 1'b1;
      if (dup_evt)     viol_col     <= 1'b1;
      if (cb_conf) begin
        edc_valid <= cb_valid_calc;
        cb_ctx    <= 1'b1;
      end
    end
  end

  a_r1_partial_flag: assert property (@(posedge clk) disable iff (!rst_n)
    partial_evt |=> viol_partial);
  a_r2_dup_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (dup_evt && !seq_start) |=> viol_col);
  a_r5_quiet_unchecked: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == SEQ_CB) && !chk_q) |-> !dup_evt);
  a_r5_invalid_unchecked: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_conf && !chk_q) |=> !edc_valid);
  a_r9_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> (!viol_col && !viol_partial && !cb_ctx));

endmodule

// File: rtl/edc_status_fmt.sv
module edc_status_fmt
  import edc_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_cmd,
  input  logic       cb_ctx,
  input  logic       edc_valid,
  input  logic       err_set,
  input  logic       err_clr,
  input  logic       proto_clr,
  input  logic       prog_fail,
  input  logic       arr_rdy,
  input  logic       rdy,
  input  logic       wp_n,
  output logic [7:0] stat_byte,
  output logic       stat_vld,
  output logic       proto_err
);
  logic edc_err_q;
  logic rd_ok;
  logic rd_bad;

  assign rd_ok  = rd_cmd && cb_ctx;
  assign rd_bad = rd_cmd && !cb_ctx;

  always_ff @(posedge clk) begin
    if (!rst_n) edc_err_q <= 1'b0;
    else        edc_err_q <= err_set || (edc_err_q && !(err_clr || rd_ok));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_byte <= 8'h00;
      stat_vld  <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      stat_vld <= rd_cmd;
      if (rd_ok)       stat_byte <= pack_status(prog_fail, edc_err_q, edc_valid,
                                                arr_rdy, rdy, wp_n);
      else if (rd_bad) stat_byte <= 8'h00;
      if (proto_clr)   proto_err <= 1'b0;
      else if (rd_bad) proto_err <= 1'b1;
    end
  end

  a_r7_zero_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_bad && !proto_clr) |=> (stat_vld && (stat_byte == 8'h00) && proto_err));
  a_r6_spare_bits: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |-> (stat_byte[4:3] == 2'b00));
  a_r6_level_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> ((stat_byte[BIT_FAIL] == $past(prog_fail)) && (stat_byte[BIT_WPN] == $past(wp_n))));
  a_r8_err_merge: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> edc_err_q);

endmodule

// File: rtl/edc_rule_monitor.sv
module edc_rule_monitor
  import edc_mon_pkg::*;
#(
  parameter int UNIT_BYTES = 528,
  parameter int UNITS      = 4,
  localparam int COL_W     = $clog2(UNIT_BYTES * UNITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic [7:0]       cmd_op,
  input  logic             wr_stb,
  input  logic [COL_W-1:0] wr_col,
  input  logic             new_page,
  input  logic             cb_start,
  input  logic             cb_chk_en,
  input  logic             cb_rd_err,
  input  logic             prog_fail,
  input  logic             arr_rdy,
  input  logic             rdy,
  input  logic             wp_n,
  output logic             viol_partial,
  output logic             viol_col,
  output logic             edc_valid,
  output logic             proto_err,
  output logic             stat_vld,
  output logic [7:0]       stat_byte
);
  logic             seq_start;
  logic             prog_start;
  logic             trk_en;
  logic             dup_evt;
  logic             cb_ctx;
  logic             rd_cmd;
  logic [UNITS-1:0] touched;
  logic [UNITS-1:0] unit_full;

  assign rd_cmd = cmd_vld && (cmd_op == OP_EDC_STATUS);

  edc_col_tracker #(.UNIT_BYTES(UNIT_BYTES), .UNITS(UNITS)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr(seq_start), .trk_en(trk_en),
    .wr_stb(wr_stb), .wr_col(wr_col), .dup_evt(dup_evt),
    .touched(touched), .unit_full(unit_full)
  );

  edc_seq_ctrl #(.UNITS(UNITS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cb_start(cb_start), .cb_chk_en(cb_chk_en), .new_page(new_page),
    .dup_evt(dup_evt), .touched(touched), .unit_full(unit_full),
    .seq_start(seq_start), .prog_start(prog_start), .trk_en(trk_en),
    .viol_partial(viol_partial), .viol_col(viol_col),
    .edc_valid(edc_valid), .cb_ctx(cb_ctx)
  );

  edc_status_fmt u_fmt (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .cb_ctx(cb_ctx),
    .edc_valid(edc_valid), .err_set(cb_rd_err), .err_clr(prog_start),
    .proto_clr(seq_start), .prog_fail(prog_fail), .arr_rdy(arr_rdy),
    .rdy(rdy), .wp_n(wp_n), .stat_byte(stat_byte), .stat_vld(stat_vld),
    .proto_err(proto_err)
  );

endmodule

// File: tb/tb_edc_rule_monitor.sv
`timescale 1ns/1ps
module tb_edc_rule_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_vld = 1'b0;
  logic [7:0]  cmd_op = 8'h00;
  logic        wr_stb = 1'b0;
  logic [11:0] wr_col = '0;
  logic        new_page = 1'b0, cb_start = 1'b0, cb_chk_en = 1'b0, cb_rd_err = 1'b0;
  logic        prog_fail = 1'b0, arr_rdy = 1'b1, rdy = 1'b1, wp_n = 1'b1;
  logic        viol_partial, viol_col, edc_valid, proto_err, stat_vld;
  logic [7:0]  stat_byte;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  edc_rule_monitor dut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .wr_stb(wr_stb), .wr_col(wr_col), .new_page(new_page),
    .cb_start(cb_start), .cb_chk_en(cb_chk_en), .cb_rd_err(cb_rd_err),
    .prog_fail(prog_fail), .arr_rdy(arr_rdy), .rdy(rdy), .wp_n(wp_n),
    .viol_partial(viol_partial), .viol_col(viol_col), .edc_valid(edc_valid),
    .proto_err(proto_err), .stat_vld(stat_vld), .stat_byte(stat_byte)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    @(negedge clk); cmd_vld = 1'b1; cmd_op = op;
    @(negedge clk); cmd_vld = 1'b0;
  endtask

  task automatic cb_open(input logic chk);
    @(negedge clk); cb_start = 1'b1; cb_chk_en = chk;
    @(negedge clk); cb_start = 1'b0;
  endtask

  task automatic wr(input int col);
    @(negedge clk); wr_stb = 1'b1; wr_col = 12'(col);
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic pulse_page();
    @(negedge clk); new_page = 1'b1;
    @(negedge clk); new_page = 1'b0;
  endtask

  task automatic pulse_err();
    @(negedge clk); cb_rd_err = 1'b1;
    @(negedge clk); cb_rd_err = 1'b0;
  endtask

  // vector: {mode[1:0], colA[11:0], colB[11:0]}; mode 0 program, 1 copy-back checked, 2 unchecked
  localparam logic [25:0] VEC [8] = '{
    {2'd0, 12'd5,    12'd5},
    {2'd0, 12'd5,    12'd6},
    {2'd1, 12'd100,  12'd100},
    {2'd1, 12'd100,  12'd628},
    {2'd2, 12'd9,    12'd9},
    {2'd2, 12'd9,    12'd10},
    {2'd0, 12'd2111, 12'd2111},
    {2'd1, 12'd0,    12'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R9 flags start clear)
    check("R9 reset viol_partial", {7'b0, viol_partial}, 8'h00);
    check("R9 reset viol_col", {7'b0, viol_col}, 8'h00);
    check("R3 reset edc_valid", {7'b0, edc_valid}, 8'h00);
    check("R7 reset proto_err", {7'b0, proto_err}, 8'h00);
    check("R6 reset stat_byte", stat_byte, 8'h00);

    // vector table: R2, R4, R5 column-repeat behaviour
    for (int i = 0; i < 8; i++) begin
      logic [1:0]  m;
      logic [11:0] a, b;
      logic        exp_dup;
      {m, a, b} = VEC[i];
      exp_dup = (m != 2'd2) && (a == b);
      pulse_page();
      if (m == 2'd0) cmd(8'h80);
      else           cb_open(m == 2'd1);
      wr(a);
      wr(b);
      check(m == 2'd0 ? "R2 vec" : (m == 2'd1 ? "R4 vec" : "R5 vec"),
            {7'b0, viol_col}, {7'b0, exp_dup});
      cmd(8'h10);
    end

    // R7: status read outside copy-back context (last confirm was a copy-back, reopen program)
    cmd(8'h80);
    cmd(8'h10);
    cmd(8'h7B);
    check("R7 stat_vld", {7'b0, stat_vld}, 8'h01);
    check("R7 zero byte", stat_byte, 8'h00);
    check("R7 proto_err", {7'b0, proto_err}, 8'h01);
    cmd(8'h80);
    check("R9 proto_err cleared", {7'b0, proto_err}, 8'h00);
    cmd(8'h10);

    // R1: partial programs per unit
    pulse_page();
    cmd(8'h80); wr(0);   cmd(8'h10);
    check("R1 first unit0", {7'b0, viol_partial}, 8'h00);
    cmd(8'h80); wr(600); cmd(8'h10);
    check("R1 first unit1", {7'b0, viol_partial}, 8'h00);
    cmd(8'h80); wr(10);  cmd(8'h10);
    check("R1 second unit0", {7'b0, viol_partial}, 8'h01);
    cmd(8'h80);
    check("R9 partial cleared", {7'b0, viol_partial}, 8'h00);
    cmd(8'h10);

    // R3/R6: full unit 1 in checked copy-back
    cb_open(1'b1);
    for (int c = 528; c < 1056; c++) wr(c);
    cmd(8'h10);
    check("R3 full unit valid", {7'b0, edc_valid}, 8'h01);
    check("R4 no repeat", {7'b0, viol_col}, 8'h00);
    cmd(8'h7B);
    check("R6 stat_vld", {7'b0, stat_vld}, 8'h01);
    check("R6 byte full", stat_byte, 8'hE4);

    // R3/R6: one column short, changed levels
    cb_open(1'b1);
    for (int c = 0; c < 527; c++) wr(c);
    cmd(8'h10);
    check("R3 short unit invalid", {7'b0, edc_valid}, 8'h00);
    prog_fail = 1'b1; wp_n = 1'b0; arr_rdy = 1'b0;
    cmd(8'h7B);
    check("R6 byte levels", stat_byte, 8'h41);
    prog_fail = 1'b0; wp_n = 1'b1; arr_rdy = 1'b1;

    // R8: merged error pulses, cleared by reporting read
    cb_open(1'b1);
    for (int c = 1056; c < 1584; c++) wr(c);
    pulse_err();
    pulse_err();
    cmd(8'h10);
    cmd(8'h7B);
    check("R8 error reported", stat_byte, 8'hE6);
    cmd(8'h7B);
    check("R8 error cleared by read", stat_byte, 8'hE4);
    pulse_err();
    cmd(8'h80);
    cmd(8'h10);
    cb_open(1'b1);
    for (int c = 1584; c < 2112; c++) wr(c);
    cmd(8'h10);
    cmd(8'h7B);
    check("R8 error cleared by 80h", stat_byte, 8'hE4);

    // R5: unchecked copy-back
    cb_open(1'b0);
    wr(3); wr(3);
    check("R5 no violation", {7'b0, viol_col}, 8'h00);
    cmd(8'h10);
    check("R5 edc_valid low", {7'b0, edc_valid}, 8'h00);
    cmd(8'h7B);
    check("R5 byte", stat_byte, 8'hE0);

    // R4 then R9 clear by copy-back start
    cb_open(1'b1);
    wr(7); wr(7);
    check("R4 repeat in copy-back", {7'b0, viol_col}, 8'h01);
    cb_open(1'b1);
    check("R9 cleared by cb_start", {7'b0, viol_col}, 8'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule